// File: doc/BRIEF.md
# Tachometer Pulse Timer and Period Counter

This block is a 16-bit counter that sits on an 8-bit register bus. It occupies two addresses. One is a control/status byte. The other is a data port that reaches the 16-bit count one byte at a time. Two mode bits and a pulse-select bit choose where the count advances from:
- a slow reference tick, which makes it a free-running timer;
- rising edges of one of two tape-tachometer pulse inputs (called fast and quarter pulses here), which makes it an event counter;
- every cycle of the 208 ns base clock, which makes it a period counter that copies the running value into a holding register at each selected pulse.

Software arms the counter by writing the upper byte of the count. The counter then runs until it carries out of its top bit, which raises an overflow flag, or until software stops it. Two detect flags record tachometer pulses seen while the motion-cycle input is high. An error bit drives a lamp output.

The pulse inputs are asynchronous. Each one passes through a two-stage synchronizer and a rising-edge detector, so a pulse acts on the third rising clock edge after it goes high. The reference tick is one base clock cycle in every eight.

Top module: `tach_timer`

## Requirements
- R1: After reset, the control byte at address 0x40 reads 0x00, the data port at address 0x41 reads 0x00, and `err_lamp` and `ovf_flag` are low. The control byte reads back as {quarter-detect[7], fast-detect[6], overflow[5], running[4], error[3], pulse-select[2], mode1[1], mode0[0]}.
- R2: A byte-select state starts at "upper". Every write or read of address 0x41 accesses the selected byte and then flips the selection. A write of 0x40 with bit 5 set returns the selection to "upper".
- R3: A write of the upper byte loads bits 15:8, sets the running state and clears the overflow flag. A write of the lower byte loads bits 7:0 and changes neither of them.
- R4: With mode1=0 and mode0=0, a running counter advances by one on every eighth base clock cycle.
- R5: With mode1=0 and mode0=1, a running counter advances once per rising edge of the fast pulse input when pulse-select=0, or of the quarter pulse input when pulse-select=1. It advances on the third rising clock edge after the input rises, and ignores the other input.
- R6: With mode1=1, a running counter advances every cycle. At each selected pulse, the pre-increment count is copied into a holding register, and reads of 0x41 return the held bytes instead of the live count.
- R7: When a running counter advances from 0xFFFF, it wraps to 0x0000, stops, and sets the overflow flag and `ovf_flag`.
- R8: A write of 0x40 with bit 4 set stops counting. The count then holds its value.
- R9: The fast-detect flag sets on a fast pulse while `mcy` is high. It clears on a write of 0x40 with bit 6 set, or on any cycle with `mcy` low. The quarter-detect flag behaves the same way for the quarter pulse, with clear bit 7.
- R10: Bit 3 of a write to 0x40 sets or clears the error bit, and `err_lamp` follows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 208 ns base clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle (advances the data-port byte select) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ftp_in | input | 1 | Fast tachometer pulse, asynchronous |
| qtp_in | input | 1 | Quarter tachometer pulse, asynchronous |
| mcy | input | 1 | Motion-cycle qualifier for the detect flags |
| err_lamp | output | 1 | Error lamp drive |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
A wrong byte-select state shows up at once: the very next data-port read returns the other half of the count. A counter that advances from the wrong source drifts away from the reference model within one tick period, which is eight cycles, or within one pulse. A missed or spurious capture changes the held value, and the next read in period mode shows it. Flag and lamp faults reach `rdata`, `err_lamp` or `ovf_flag` one cycle after the causing edge, because the bench compares every output against its model on every cycle.

// File: rtl/tach_pkg.sv
package tach_pkg;

    // Control byte bit positions (read and write)
    localparam int CB_M0   = 0;
    localparam int CB_M1   = 1;
    localparam int CB_PSEL = 2;
    localparam int CB_ERR  = 3;
    localparam int CB_STOP = 4;  // write strobe: stop; read: running
    localparam int CB_BSEL = 5;  // write strobe: byte select to upper; read: overflow
    localparam int CB_CLRF = 6;  // write strobe: clear fast flag; read: fast flag
    localparam int CB_CLRQ = 7;  // write strobe: clear quarter flag; read: quarter flag

    typedef enum logic [1:0] {
        SRC_TICK   = 2'd0,
        SRC_PULSE  = 2'd1,
        SRC_PERIOD = 2'd2
    } tach_src_e;

    function automatic tach_src_e tach_decode(input logic m0, input logic m1);
        if (m1)      return SRC_PERIOD;
        else if (m0) return SRC_PULSE;
        else         return SRC_TICK;
    endfunction

endpackage

// File: rtl/tach_pulse_sync.sv
module tach_pulse_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
            last_q <= chain_q[SYNC_STAGES-1];
        end
    end

    assign pulse = chain_q[SYNC_STAGES-1] & ~last_q;

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int PRESCALE = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);

    generate
        if (PRESCALE > 1) begin : g_gap
            // R4
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/tach_core.sv
module tach_core
    import tach_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BYTE_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick,
    input  logic              ftp_p,
    input  logic              qtp_p,
    input  logic              mcy,
    output logic              err_lamp,
    output logic              ovf_flag
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic             m0;
        logic             m1;
        logic             psel;
        logic             err;
        logic             run;
        logic             ovf;
        logic             lower;
        logic             fdet;
        logic             qdet;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } core_state_t;

    core_state_t s_d, s_q;
    tach_src_e   src;
    logic        sel_pulse, adv, ctrl_wr, data_wr, data_rd;
    logic [CNT_W-1:0] view;

    assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
    assign data_wr = wr_en && (addr == DATA_ADDR);
    assign data_rd = rd_en && !wr_en && (addr == DATA_ADDR);

    always_comb begin
        s_d       = s_q;
        src       = tach_decode(s_q.m0, s_q.m1);
        sel_pulse = s_q.psel ? qtp_p : ftp_p;
        case (src)
            SRC_TICK:  adv = tick;
            SRC_PULSE: adv = sel_pulse;
            default:   adv = 1'b1;
        endcase

        if (src == SRC_PERIOD && sel_pulse) s_d.hold = s_q.cnt;

        if (s_q.run && adv) begin
            if (&s_q.cnt) begin
                s_d.cnt = '0;
                s_d.ovf = 1'b1;
                s_d.run = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end

        if (ftp_p && mcy) s_d.fdet = 1'b1;
        if (qtp_p && mcy) s_d.qdet = 1'b1;
        if (!mcy) begin
            s_d.fdet = 1'b0;
            s_d.qdet = 1'b0;
        end

        if (ctrl_wr) begin
            s_d.m0   = wdata[CB_M0];
            s_d.m1   = wdata[CB_M1];
            s_d.psel = wdata[CB_PSEL];
            s_d.err  = wdata[CB_ERR];
            if (wdata[CB_STOP]) s_d.run   = 1'b0;
            if (wdata[CB_BSEL]) s_d.lower = 1'b0;
            if (wdata[CB_CLRF]) s_d.fdet  = 1'b0;
            if (wdata[CB_CLRQ]) s_d.qdet  = 1'b0;
        end

        if (data_wr) begin
            if (!s_q.lower) begin
                s_d.cnt[CNT_W-1:BYTE_W] = wdata;
                s_d.run = 1'b1;
                s_d.ovf = 1'b0;
            end else begin
                s_d.cnt[BYTE_W-1:0] = wdata;
            end
            s_d.lower = ~s_q.lower;
        end else if (data_rd) begin
            s_d.lower = ~s_q.lower;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        view  = s_q.m1 ? s_q.hold : s_q.cnt;
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[CB_M0]   = s_q.m0;
            rdata[CB_M1]   = s_q.m1;
            rdata[CB_PSEL] = s_q.psel;
            rdata[CB_ERR]  = s_q.err;
            rdata[CB_STOP] = s_q.run;
            rdata[CB_BSEL] = s_q.ovf;
            rdata[CB_CLRF] = s_q.fdet;
            rdata[CB_CLRQ] = s_q.qdet;
        end else if (addr == DATA_ADDR) begin
            rdata = s_q.lower ? view[BYTE_W-1:0] : view[CNT_W-1:BYTE_W];
        end
    end

    assign err_lamp = s_q.err;
    assign ovf_flag = s_q.ovf;

    logic [CNT_W-1:0] cnt_w, hold_w;
    logic ovf_w, run_w, lower_w, fdet_w, qdet_w, cap_w;
    assign cnt_w   = s_q.cnt;
    assign hold_w  = s_q.hold;
    assign ovf_w   = s_q.ovf;
    assign run_w   = s_q.run;
    assign lower_w = s_q.lower;
    assign fdet_w  = s_q.fdet;
    assign qdet_w  = s_q.qdet;
    assign cap_w   = (src == SRC_PERIOD) && sel_pulse;

    // R7
    ovf_from_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_w) |-> ($past(cnt_w) == '1 && $past(run_w)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !data_wr) |=> $stable(cnt_w));
    // R9
    mcy_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mcy |=> (!fdet_w && !qdet_w));
    // R6
    hold_only_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_w |=> $stable(hold_w));
    // R3
    arm_on_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !lower_w) |=> (run_w && !ovf_w));

endmodule

// File: rtl/tach_timer.sv
module tach_timer #(
    parameter int ADDR_W      = 7,
    parameter int BYTE_W      = 8,
    parameter int PRESCALE    = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              ftp_in,
    input  logic              qtp_in,
    input  logic              mcy,
    output logic              err_lamp,
    output logic              ovf_flag
);
    localparam int NPULSE = 2;

    logic [NPULSE-1:0] raw_in, pulses;
    logic              tick;

    assign raw_in = {qtp_in, ftp_in};

    generate
        for (genvar g = 0; g < NPULSE; g++) begin : g_sync
            tach_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .async_in(raw_in[g]), .pulse(pulses[g])
            );
        end
    endgenerate

    tach_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tach_core #(
        .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
        .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .ftp_p(pulses[0]),
        .qtp_p(pulses[1]), .mcy(mcy), .err_lamp(err_lamp), .ovf_flag(ovf_flag)
    );

endmodule

// File: tb/tb_tach_timer.sv
module tb_tach_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = 7'h40;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ftp_in = 1'b0, qtp_in = 1'b0, mcy = 1'b0;
    logic       err_lamp, ovf_flag;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    tach_timer dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ftp_in(ftp_in), .qtp_in(qtp_in),
        .mcy(mcy), .err_lamp(err_lamp), .ovf_flag(ovf_flag)
    );

    // Behavioural reference model
    int m_m0, m_m1, m_ps, m_err, m_run, m_ovf, m_low, m_fd, m_qd;
    int m_cnt, m_hold, m_pre;
    bit fq[$], qq[$];   // input history, newest first

    task automatic model_reset();
        m_m0 = 0; m_m1 = 0; m_ps = 0; m_err = 0; m_run = 0; m_ovf = 0;
        m_low = 0; m_fd = 0; m_qd = 0; m_cnt = 0; m_hold = 0; m_pre = 0;
        fq = '{0, 0, 0}; qq = '{0, 0, 0};
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit fp, qp, sp, tk, adv;
            fp = fq[1] && !fq[2];
            qp = qq[1] && !qq[2];
            fq.push_front(ftp_in); void'(fq.pop_back());
            qq.push_front(qtp_in); void'(qq.pop_back());
            tk = (m_pre == 7);
            m_pre = (m_pre + 1) % 8;
            sp = m_ps ? qp : fp;
            adv = m_m1 ? 1 : (m_m0 ? sp : tk);
            if (m_m1 && sp) m_hold = m_cnt;
            if (m_run && adv) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; m_run = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (fp && mcy) m_fd = 1;
            if (qp && mcy) m_qd = 1;
            if (!mcy) begin m_fd = 0; m_qd = 0; end
            if (wr_en && addr == 7'h40) begin
                m_m0 = wdata[0]; m_m1 = wdata[1]; m_ps = wdata[2]; m_err = wdata[3];
                if (wdata[4]) m_run = 0;
                if (wdata[5]) m_low = 0;
                if (wdata[6]) m_fd = 0;
                if (wdata[7]) m_qd = 0;
            end
            if (wr_en && addr == 7'h41) begin
                if (!m_low) begin
                    m_cnt = (m_cnt & 255) | (int'(wdata) << 8); m_run = 1; m_ovf = 0;
                end else m_cnt = (m_cnt & 65280) | int'(wdata);
                m_low = !m_low;
            end else if (rd_en && addr == 7'h41) m_low = !m_low;
        end
    end

    function automatic logic [7:0] exp_rdata();
        int v;
        if (addr == 7'h40)
            return 8'((m_qd << 7) | (m_fd << 6) | (m_ovf << 5) | (m_run << 4) |
                      (m_err << 3) | (m_ps << 2) | (m_m1 << 1) | m_m0);
        if (addr == 7'h41) begin
            v = m_m1 ? m_hold : m_cnt;
            return m_low ? 8'(v & 255) : 8'(v >> 8);
        end
        return 8'h00;
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("rdata", rdata, exp_rdata());
            check("err_lamp", err_lamp, m_err);
            check("ovf_flag", ovf_flag, m_ovf);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [6:0] a, logic [7:0] d);
        @(negedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic rd(logic [6:0] a);
        @(negedge clk); #1; addr = a; rd_en = 1'b1;
        @(negedge clk); #1; rd_en = 1'b0;
    endtask

    task automatic pulse(bit quarter);
        @(negedge clk); #1;
        if (quarter) qtp_in = 1'b1; else ftp_in = 1'b1;
        idle(3); #1;
        if (quarter) qtp_in = 1'b0; else ftp_in = 1'b0;
        idle(3);
    endtask

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3); #1; rst_n = 1'b1;
        cur_req = "R1"; idle(2); rd(7'h41); addr = 7'h40; idle(2);
        cur_req = "R2";
        wr(7'h41, 8'h12); wr(7'h41, 8'h34);
        rd(7'h41); rd(7'h41); rd(7'h41);
        wr(7'h40, 8'h20); rd(7'h41); addr = 7'h41;
        cur_req = "R4"; idle(40);
        cur_req = "R8"; wr(7'h40, 8'h10); addr = 7'h41; idle(20); rd(7'h41); rd(7'h41);
        cur_req = "R3";
        wr(7'h40, 8'h30); wr(7'h41, 8'h00); wr(7'h40, 8'h10); wr(7'h40, 8'h20);
        wr(7'h41, 8'hAB); rd(7'h41); addr = 7'h40; idle(4);
        cur_req = "R5";
        wr(7'h40, 8'h21); wr(7'h41, 8'h00); wr(7'h41, 8'h00); addr = 7'h41;
        pulse(0); pulse(0); pulse(0); pulse(1); pulse(1);
        wr(7'h40, 8'h25); addr = 7'h41; pulse(1); pulse(0); pulse(1);
        rd(7'h41); rd(7'h41);
        cur_req = "R9"; addr = 7'h40; mcy = 1'b1;
        pulse(0); wr(7'h40, 8'h45); pulse(1); pulse(0);
        wr(7'h40, 8'h85); pulse(1); idle(2); mcy = 1'b0; idle(3);
        cur_req = "R6";
        wr(7'h40, 8'h22); wr(7'h41, 8'h00); wr(7'h41, 8'h10); addr = 7'h41;
        idle(5); pulse(0); rd(7'h41); rd(7'h41); idle(7); pulse(1); pulse(0);
        wr(7'h40, 8'h26); addr = 7'h41; pulse(1); rd(7'h41); rd(7'h41);
        cur_req = "R7";
        wr(7'h40, 8'h22); wr(7'h41, 8'hFF); wr(7'h41, 8'hF0); addr = 7'h40;
        idle(30); wr(7'h41, 8'h00); addr = 7'h40; idle(4);
        cur_req = "R10";
        wr(7'h40, 8'h18); idle(3); wr(7'h40, 8'h10); idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule